// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is an up-counting timer that raises a periodic interrupt. Software programs a compare value, a count clock divide select and a mode through a simple strobed register write port. Once the interval mode is enabled, a prescaler divides the system clock. On every count tick the counter either advances by one or, when it equals the compare value, returns to zero. That match also produces a single-cycle interrupt pulse.

The interval between interrupts is (compare + 1) count ticks. A combinational read port returns any register, including the live counter value and a sticky overflow flag. The flag records a wrap past the counter's maximum that happened without a match. This can occur when the compare value is lowered below the current count. The counter width is a parameter (16 by default).

Top module: `itv_timer`

## Requirements
- R1: After reset every register reads 0, the counter reads 0 and irq_o is low.
- R2: The timer runs only while mode bits 3:2 are 2'b11 and bit 0 of the compare-control register is 0. In any other setting the counter is held at 0 and irq_o stays low.
- R3: The counter advances by one per count tick. The divide select is 3 bits: its bits 1:0 come from bits 1:0 of register 3, and its bit 2 comes from bit 0 of register 4. Codes 0 to 5 divide the system clock by 2, 4, 8, 16, 32 and 64. Codes 6 and 7 divide by 256.
- R4: On a tick where the counter equals the compare value, the counter clears to 0 and irq_o pulses high for one cycle. The pulse appears in the same cycle the counter reads 0. With compare N and divide D, the pulse appears (N+1)*D cycles after the enabling write, and again every (N+1)*D cycles after that.
- R5: A compare value of 0 gives an interrupt on every count tick.
- R6: Entering the interval mode from stop restarts the prescaler and counter from 0, so the first tick lands D cycles after the enabling write edge.
- R7: A wrap from the counter's maximum to 0 with no match sets the overflow flag, which reads as bit 0 of register 0. A match at the maximum value does not set it.
- R8: The overflow flag is sticky. A write to register 0 with bit 0 = 0 clears it. A write with bit 0 = 1 leaves it unchanged. A wrap in the same cycle wins over a clear.
- R9: Register map: 0 mode, 1 compare-control, 2 compare, 3 divide-low, 4 divide-high, 5 counter (read only). Mode bits 7:4 and compare-control bits 7:3 read 0. Register 3 keeps only bits 1:0 and register 4 keeps only bit 0. Writes to address 5 are ignored.
- R10: A compare write made while running is used from the next count tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write register address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 3 | Read register address |
| rd_data_o | output | DATA_W | Read data, combinational |
| irq_o | output | 1 | One-cycle interrupt pulse on compare match |

## Verification
The bench uses an 8-bit counter. It sweeps all eight divide codes against compare values 0, 1, 3 and 6, and predicts the counter and interrupt in every cycle from the tick arithmetic. This separates wrong divide ratios, off-by-one periods and a missing restart on enable. A compare value at the counter's maximum shows that a match there does not count as overflow. Lowering the compare value mid-count forces a real wrap, which exposes the flag's timing, the point where the new compare value takes effect, and the flag's set and clear rules. Stopped and capture-style settings show that the counter is held.

// File: rtl/itv_pkg.sv
package itv_pkg;
  typedef logic [2:0] addr_t;

  localparam addr_t ADDR_MODE = 3'd0;
  localparam addr_t ADDR_CCR  = 3'd1;
  localparam addr_t ADDR_CMP  = 3'd2;
  localparam addr_t ADDR_PSC0 = 3'd3;
  localparam addr_t ADDR_PSC1 = 3'd4;
  localparam addr_t ADDR_CNT  = 3'd5;

  localparam logic [1:0] MODE_CLR_ON_MATCH = 2'b11;
  localparam logic [2:0] SEL_MAX_POW       = 3'd5;
endpackage

// File: rtl/itv_regs.sv
module itv_regs
  import itv_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  addr_t             wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  addr_t             rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              ovf_set_i,
  output logic              run_o,
  output logic [2:0]        sel_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              ovf_o
);
  logic [3:1]       mode_q;
  logic [2:0]       ccr_q;
  logic [CNT_W-1:0] cmp_q;
  logic [1:0]       psc0_q;
  logic             psc1_q;
  logic             ovf_q;

  logic wr_mode;
  assign wr_mode = wr_en_i && (wr_addr_i == ADDR_MODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ccr_q  <= '0;
      cmp_q  <= '0;
      psc0_q <= '0;
      psc1_q <= 1'b0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_MODE: mode_q <= wr_data_i[3:1];
        ADDR_CCR:  ccr_q  <= wr_data_i[2:0];
        ADDR_CMP:  cmp_q  <= wr_data_i[CNT_W-1:0];
        ADDR_PSC0: psc0_q <= wr_data_i[1:0];
        ADDR_PSC1: psc1_q <= wr_data_i[0];
        default: ;
      endcase
    end
  end

  // wrap wins over a same-cycle software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ovf_q <= 1'b0;
    else if (ovf_set_i)              ovf_q <= 1'b1;
    else if (wr_mode && !wr_data_i[0]) ovf_q <= 1'b0;
  end

  assign run_o = (mode_q[3:2] == MODE_CLR_ON_MATCH) && !ccr_q[0];
  assign sel_o = {psc1_q, psc0_q};
  assign cmp_o = cmp_q;
  assign ovf_o = ovf_q;

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      ADDR_MODE: rd_data_o[3:0]       = {mode_q, ovf_q};
      ADDR_CCR:  rd_data_o[2:0]       = ccr_q;
      ADDR_CMP:  rd_data_o[CNT_W-1:0] = cmp_q;
      ADDR_PSC0: rd_data_o[1:0]       = psc0_q;
      ADDR_PSC1: rd_data_o[0]         = psc1_q;
      ADDR_CNT:  rd_data_o[CNT_W-1:0] = cnt_i;
      default:   rd_data_o            = '0;
    endcase
  end
endmodule

// File: rtl/itv_prescaler.sv
module itv_prescaler
  import itv_pkg::*;
#(
  parameter int PSC_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] mask;

  // divide 2^(sel+1) for sel<=5, else full 2^PSC_W
  always_comb begin
    for (int b = 0; b < PSC_W; b++) begin
      mask[b] = (sel_i > SEL_MAX_POW) || (b <= int'(sel_i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     psc_q <= '0;
    else if (!run_i) psc_q <= '0;
    else             psc_q <= psc_q + 1'b1;
  end

  assign tick_o = run_i && ((psc_q & mask) == mask);
endmodule

// File: rtl/itv_counter.sv
module itv_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             ovf_set_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic             match;

  assign match = (cnt_q == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= run_i && tick_i && match;
      if (!run_i)      cnt_q <= '0;
      else if (tick_i) cnt_q <= match ? '0 : cnt_q + 1'b1;
    end
  end

  assign ovf_set_o = run_i && tick_i && !match && (&cnt_q);
  assign cnt_o     = cnt_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/itv_timer.sv
module itv_timer
  import itv_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int PSC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic             run_w;
  logic             tick_w;
  logic [2:0]       sel_w;
  logic [CNT_W-1:0] cmp_w;
  logic [CNT_W-1:0] cnt_w;
  logic             ovf_set_w;
  logic             ovf_w;

  itv_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .cnt_i     (cnt_w),
    .ovf_set_i (ovf_set_w),
    .run_o     (run_w),
    .sel_o     (sel_w),
    .cmp_o     (cmp_w),
    .ovf_o     (ovf_w)
  );

  itv_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_w),
    .sel_i  (sel_w),
    .tick_o (tick_w)
  );

  itv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_w),
    .tick_i    (tick_w),
    .cmp_i     (cmp_w),
    .cnt_o     (cnt_w),
    .irq_o     (irq_o),
    .ovf_set_o (ovf_set_w)
  );
endmodule

// File: rtl/itv_timer_chk.sv
module itv_timer_chk
  import itv_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [2:0]       wr_addr_i,
  input logic             wr_bit0_i,
  input logic             run_i,
  input logic             tick_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cmp_i,
  input logic             irq_i,
  input logic             ovf_i
);
  a_r2_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_i == '0) && !irq_i);

  a_r3_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(cnt_i));

  a_r3_step_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && (cnt_i != cmp_i)) |=> (cnt_i == $past(cnt_i) + 1'b1));

  a_r4_irq_with_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (cnt_i == '0));

  a_r4_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i);

  a_r7_wrap_sets_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && (&cnt_i) && (cnt_i != cmp_i)) |=> ovf_i);

  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !(wr_en_i && (wr_addr_i == ADDR_MODE) && !wr_bit0_i)) |=> ovf_i);
endmodule

bind itv_timer itv_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_bit0_i (wr_data_i[0]),
  .run_i     (run_w),
  .tick_i    (tick_w),
  .cnt_i     (cnt_w),
  .cmp_i     (cmp_w),
  .irq_i     (irq_o),
  .ovf_i     (ovf_w)
);

// File: tb/tb_itv_timer.sv
module tb_itv_timer;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [2:0]        wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [2:0]        rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              irq;

  int errs   = 0;
  int checks = 0;

  always #2 clk = ~clk;

  itv_timer #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .irq_o     (irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = DATA_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string tag, input int a, input int exp);
    rd_addr = 3'(a);
    #0.5;
    check(tag, int'(rd_data), exp);
  endtask

  function automatic int div_of(input int s);
    return (s < 6) ? (2 << s) : 256;
  endfunction

  // sweep one configuration, predicting counter and irq every cycle
  task automatic run_cfg(input int s, input int n);
    int d, per, bad_c, bad_i, ac, ec, ai, ei;
    wr(0, 0);
    rd_check("R2 counter cleared on stop", 5, 0);
    wr(2, n); wr(3, s & 3); wr(4, s >> 2); wr(1, 0);
    rd_addr = 3'd5;
    wr(0, 'h0C);
    d = div_of(s); per = (n + 1) * d;
    bad_c = 0; bad_i = 0; ac = 0; ec = 0; ai = 0; ei = 0;
    for (int i = 1; i <= 2 * per; i++) begin
      @(posedge clk); #1;
      if (!bad_c && int'(rd_data) != (i / d) % (n + 1)) begin
        bad_c = 1; ac = int'(rd_data); ec = (i / d) % (n + 1);
      end
      if (!bad_i && int'(irq) != int'(i % per == 0)) begin
        bad_i = 1; ai = int'(irq); ei = int'(i % per == 0);
      end
    end
    check($sformatf("R3 R6 counter trace sel=%0d cmp=%0d", s, n), ac, ec);
    if (n == 0) check($sformatf("R5 irq every tick sel=%0d", s), ai, ei);
    else        check($sformatf("R4 irq period sel=%0d cmp=%0d", s, n), ai, ei);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int bad, ai, ei, ar, er;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq low in reset", int'(irq), 0);
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 6; a++) rd_check($sformatf("R1 reg %0d after reset", a), a, 0);

    // R9 reserved bits and read-only counter
    wr(0, 'hF2); rd_check("R9 mode upper bits drop", 0, 'h02);
    wr(1, 'hFF); rd_check("R9 ccr keeps bits 2:0", 1, 'h07);
    wr(3, 'hFF); rd_check("R9 divide-low keeps 1:0", 3, 'h03);
    wr(4, 'hFF); rd_check("R9 divide-high keeps bit 0", 4, 'h01);
    wr(5, 'h33); rd_check("R9 counter write ignored", 5, 0);

    // R2 non-interval settings stay stopped
    wr(3, 0); wr(4, 0); wr(2, 2); wr(1, 1); wr(0, 'h0C);
    bad = 0; rd_addr = 3'd5;
    for (int i = 0; i < 64; i++) begin
      @(posedge clk); #1;
      if (rd_data != 0 || irq) bad = 1;
    end
    check("R2 capture setting holds counter", bad, 0);
    wr(1, 0); wr(0, 'h08);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      @(posedge clk); #1;
      if (rd_data != 0 || irq) bad = 1;
    end
    check("R2 mode 2'b10 holds counter", bad, 0);
    wr(0, 'h04);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      @(posedge clk); #1;
      if (rd_data != 0 || irq) bad = 1;
    end
    check("R2 mode 2'b01 holds counter", bad, 0);

    // sweep all divide codes over small compare values
    for (int s = 0; s < 8; s++) begin
      run_cfg(s, 0); run_cfg(s, 1); run_cfg(s, 3); run_cfg(s, 6);
    end

    // R7 match at counter maximum is not an overflow
    run_cfg(0, 255);
    rd_check("R7 no overflow on match at max", 0, 'h0C);

    // R7 R10 lower compare below count to force a wrap
    wr(0, 0); wr(3, 0); wr(4, 0); wr(1, 0); wr(2, 200);
    rd_addr = 3'd0;
    wr(0, 'h0C);
    bad = 0;
    for (int i = 1; i <= 40; i++) begin
      @(posedge clk); #1;
      if (rd_data != 'h0C || irq) bad = 1;
    end
    check("R7 no flag before wrap", bad, 0);
    wr(2, 5); // lands at edge 41, counter at 20
    rd_addr = 3'd0;
    bad = 0; ai = 0; ei = 0; ar = 0; er = 0;
    for (int i = 42; i <= 530; i++) begin
      @(posedge clk); #1;
      if (bad == 0 && int'(rd_data) != ((i >= 512) ? 'h0D : 'h0C)) begin
        bad = 1; ar = int'(rd_data); er = (i >= 512) ? 'h0D : 'h0C;
      end
      if (bad < 2 && int'(irq) != int'(i == 524)) begin
        bad = bad + 2; ai = int'(irq); ei = int'(i == 524);
      end
    end
    check("R7 flag set at wrap edge", ar, er);
    check("R10 new compare used after wrap", ai, ei);

    // R8 sticky flag, clear on bit0=0 only
    wr(0, 'h0D); rd_check("R8 write 1 keeps flag", 0, 'h0D);
    wr(0, 'h0C); rd_check("R8 write 0 clears flag", 0, 'h0C);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule